// File: doc/BRIEF.md
# Microsecond Interval Timer

A down-counting interval timer that advances on a one-microsecond tick strobe supplied by the clock tree. Software programs a single command word that holds an enable flag, an auto-reload flag and a 29-bit count. The counter expires on the tick after it reaches zero, which gives a period of count plus one ticks. When it expires the timer raises a level-high interrupt. In one-shot mode it then stops itself. In periodic mode it reloads the programmed count on the same tick.

The interrupt stays asserted until software writes the clear bit in the status word. Reading the status word returns the live count and the pending flag. A write to the command word restarts the timer at once. A write of zero stops it. The block has a simple write/read port with a small byte address and one interrupt output.

Top module: `usec_interval_timer`

## Requirements
- R1: The command word is at byte offset 0. Bit 31 is enable, bit 30 selects periodic mode, and bits 28:0 hold the count n. A write with bit 31 set loads the counter with n at once and restarts it, even while it is running. Reading offset 0 returns enable in bit 31, periodic in bit 30 and n in bits 28:0.
- R2: While enabled, the counter drops by one on each cycle with `tick_1us` high. It does not change on cycles without a tick.
- R3: After a load of n, the timer expires on tick number n+1 and raises `irq`. `irq` is level sensitive and active high. The count ranges from n = 0 (one tick) up to 0x1FFFFFFF.
- R4: In one-shot mode (bit 30 = 0), expiry clears the enable. The count then rests at 0 and no further interrupt is raised.
- R5: In periodic mode (bit 30 = 1), the counter reloads n on the expiring tick, so interrupts recur every n+1 ticks. For example, n = 9999 gives 10000 ticks.
- R6: Writing a word with bit 31 clear to offset 0 stops the timer. Later ticks raise no interrupt.
- R7: `irq` stays high until a write to the status word at byte offset 4 with bit 30 set. A status write with bit 30 clear has no effect.
- R8: If an expiry and a clear write fall in the same cycle, the expiry wins and `irq` stays high.
- R9: Reading offset 4 returns the current count in bits 28:0 and the pending flag in bit 30. All other bits read as 0.
- R10: After reset, `irq` is low and both words read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1us | input | 1 | One-cycle strobe per microsecond |
| bus_wr | input | 1 | Write strobe for `bus_addr` / `bus_wdata` |
| bus_addr | input | 8 | Byte address: 0 = command, 4 = status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Level-high interrupt |

## Verification
The hardest case to reach is a clear write that lands in exactly the same cycle as an expiry. The bench brings it about with a periodic load of count 0, which expires on every tick. It then raises the tick strobe and the clear write together in one cycle and confirms that the interrupt is still high. Long periods are reached by driving the tick strobe on every clock, so the 10000-tick periodic case completes in about ten thousand cycles.

// File: rtl/usec_timer_pkg.sv
// Package: shared widths, bit positions and the decoded command type for the
// microsecond interval timer. Bit positions are fixed by the software view.
package usec_timer_pkg;
    localparam int DATA_W   = 32;
    localparam int CNT_W    = 29;
    localparam int EN_BIT   = 31;
    localparam int PER_BIT  = 30;
    localparam int PEND_BIT = 30;

    typedef struct packed {
        logic             en;
        logic             per;
        logic [CNT_W-1:0] val;
    } load_cmd_t;
endpackage

// File: rtl/usec_timer_regif.sv
// Module: usec_timer_regif
// Decodes register writes into a load command and a clear strobe.
// Muxes the read data for the addressed word.
// Assumes single-cycle write strobes and a combinational read.
module usec_timer_regif
    import usec_timer_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int OFS_LOAD = 0,
    parameter int OFS_STAT = 4
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              armed,
    input  logic              periodic,
    input  logic [CNT_W-1:0]  reload,
    input  logic              pending,
    output logic              load_stb,
    output load_cmd_t         load_cmd,
    output logic              clr_stb,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [ADDR_W-1:0] A_LOAD = ADDR_W'(OFS_LOAD);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

    logic unused_wbit;
    assign unused_wbit = bus_wdata[CNT_W];

    // Write decode: command write and status clear strobe
    always_comb begin
        load_stb     = bus_wr && (bus_addr == A_LOAD);
        load_cmd.en  = bus_wdata[EN_BIT];
        load_cmd.per = bus_wdata[PER_BIT];
        load_cmd.val = bus_wdata[CNT_W-1:0];
        clr_stb      = bus_wr && (bus_addr == A_STAT) && bus_wdata[PEND_BIT];
    end

    // Read mux: command word readback or live status
    always_comb begin
        rdata = '0;
        if (bus_addr == A_LOAD) begin
            rdata[EN_BIT]      = armed;
            rdata[PER_BIT]     = periodic;
            rdata[CNT_W-1:0]   = reload;
        end else if (bus_addr == A_STAT) begin
            rdata[PEND_BIT]    = pending;
            rdata[CNT_W-1:0]   = cnt;
        end
    end
endmodule

// File: rtl/usec_timer_counter.sv
// Module: usec_timer_counter
// Down counter advanced by the tick strobe, with one-shot and auto-reload modes.
// A load command takes priority over a tick in the same cycle.
// Expiry is a one-cycle pulse on the tick where an armed count sits at zero.
module usec_timer_counter
    import usec_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load_stb,
    input  load_cmd_t        load_cmd,
    output logic [CNT_W-1:0] cnt,
    output logic             armed,
    output logic             periodic,
    output logic [CNT_W-1:0] reload,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Expiry: armed, ticking, no restart, count exhausted
    assign expire = armed && tick && !load_stb && (cnt == '0);

    // Counter state: load, decrement, reload or stop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            armed    <= 1'b0;
            periodic <= 1'b0;
            reload   <= '0;
        end else if (load_stb) begin
            cnt      <= load_cmd.val;
            armed    <= load_cmd.en;
            periodic <= load_cmd.per;
            reload   <= load_cmd.val;
        end else if (armed && tick) begin
            if (cnt != '0)
                cnt <= cnt - ONE;
            else if (periodic)
                cnt <= reload;
            else
                armed <= 1'b0;
        end
    end

    a_r2_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && tick && !load_stb && cnt != '0) |=> (cnt == $past(cnt) - ONE));
    a_r2_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load_stb) |=> $stable(cnt));
    a_r4_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !periodic) |=> (!armed && cnt == '0));
    a_r5_auto_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && periodic) |=> (armed && cnt == $past(reload)));
    a_r1_restart: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> (cnt == $past(load_cmd.val) && armed == $past(load_cmd.en)));
endmodule

// File: rtl/usec_timer_irq.sv
// Module: usec_timer_irq
// Pending-interrupt latch: set by expiry, cleared by a software clear strobe.
// When both arrive in one cycle, the expiry wins.
module usec_timer_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic clr_stb,
    output logic pending
);
    // Pending latch with set priority
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending <= 1'b0;
        else if (expire)
            pending <= 1'b1;
        else if (clr_stb)
            pending <= 1'b0;
    end

    a_r3_set_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> pending);
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stb && !expire) |=> !pending);
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !clr_stb) |=> pending);
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stb && expire) |=> pending);
endmodule

// File: rtl/usec_interval_timer.sv
// Module: usec_interval_timer (top)
// One-shot / periodic microsecond interval timer with a level-high interrupt.
// Assumes tick_1us is a one-cycle strobe synchronous to clk.
module usec_interval_timer
    import usec_timer_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1us,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);
    logic             load_stb, clr_stb, expire;
    load_cmd_t        load_cmd;
    logic [CNT_W-1:0] cnt, reload;
    logic             armed, periodic, pending;

    usec_timer_regif #(.ADDR_W(ADDR_W)) u_regif (
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .cnt(cnt), .armed(armed), .periodic(periodic), .reload(reload),
        .pending(pending), .load_stb(load_stb), .load_cmd(load_cmd),
        .clr_stb(clr_stb), .rdata(bus_rdata)
    );

    usec_timer_counter u_counter (
        .clk(clk), .rst_n(rst_n), .tick(tick_1us), .load_stb(load_stb),
        .load_cmd(load_cmd), .cnt(cnt), .armed(armed), .periodic(periodic),
        .reload(reload), .expire(expire)
    );

    usec_timer_irq u_irq (
        .clk(clk), .rst_n(rst_n), .expire(expire), .clr_stb(clr_stb),
        .pending(pending)
    );

    assign irq = pending;

    a_r10_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!irq && cnt == '0 && !armed));
endmodule

// File: tb/usec_interval_timer_bench.sv
`timescale 1ns/1ps
module usec_interval_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1us = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    usec_interval_timer u_usec_interval_timer (
        .clk(clk), .rst_n(rst_n), .tick_1us(tick_1us), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq)
    );

    typedef struct packed {
        logic [28:0] n;
        logic        per;
        logic [15:0] k;
        logic        exp_irq;
        logic [28:0] exp_cnt;
    } vec_t;

    // count, periodic, ticks applied, expected irq, expected count
    localparam vec_t VECS [8] = '{
        '{29'd5,    1'b0, 16'd3,     1'b0, 29'd2},
        '{29'd5,    1'b0, 16'd6,     1'b1, 29'd0},
        '{29'd5,    1'b0, 16'd9,     1'b1, 29'd0},
        '{29'd5,    1'b1, 16'd6,     1'b1, 29'd5},
        '{29'd5,    1'b1, 16'd8,     1'b1, 29'd3},
        '{29'd0,    1'b0, 16'd1,     1'b1, 29'd0},
        '{29'd9999, 1'b1, 16'd9999,  1'b0, 29'd0},
        '{29'd9999, 1'b1, 16'd10000, 1'b1, 29'd9999}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic ticks(input int k);
        @(negedge clk);
        for (int i = 0; i < k; i++) begin
            tick_1us = 1'b1;
            @(negedge clk);
        end
        tick_1us = 1'b0;
    endtask

    task automatic quiesce();
        wr(8'd0, 32'd0);
        wr(8'd4, 32'h4000_0000);
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        check("R10 irq", {31'd0, irq}, 32'd0);
        rd(8'd0, d); check("R10 cmd word", d, 32'd0);
        rd(8'd4, d); check("R10 status word", d, 32'd0);

        // Vector table: R3 R4 R5 R2 behaviour across counts and modes
        foreach (VECS[i]) begin
            quiesce();
            wr(8'd0, {1'b1, VECS[i].per, 1'b0, VECS[i].n});
            ticks(int'(VECS[i].k));
            check("R3/R4/R5 vector irq", {31'd0, irq}, {31'd0, VECS[i].exp_irq});
            rd(8'd4, d);
            check("R9/R2 vector count", {3'd0, d[28:0]}, {3'd0, VECS[i].exp_cnt});
            check("R9 vector pending bit", {31'd0, d[30]}, {31'd0, VECS[i].exp_irq});
        end

        // R1 readback of command fields and maximum count
        quiesce();
        wr(8'd0, 32'hDFFF_FFFF);
        rd(8'd0, d); check("R1 cmd readback max", d, 32'hDFFF_FFFF);
        rd(8'd4, d); check("R3 max count loaded", d, 32'h1FFF_FFFF);

        // R2 no decrement without tick
        repeat (5) @(negedge clk);
        rd(8'd4, d); check("R2 hold without tick", d, 32'h1FFF_FFFF);

        // R1 restart while running
        quiesce();
        wr(8'd0, 32'h8000_0008);
        ticks(5);
        wr(8'd0, 32'h8000_0008);
        rd(8'd4, d); check("R1 restart reload", d, 32'h0000_0008);
        ticks(8);
        check("R1 no early expiry after restart", {31'd0, irq}, 32'd0);
        ticks(1);
        check("R1 expiry after restart", {31'd0, irq}, 32'd1);

        // R6 stop by writing zero
        quiesce();
        wr(8'd0, 32'h8000_0003);
        ticks(2);
        wr(8'd0, 32'd0);
        ticks(10);
        check("R6 stopped no irq", {31'd0, irq}, 32'd0);
        rd(8'd0, d); check("R6 enable cleared", {31'd0, d[31]}, 32'd0);

        // R7 clear semantics
        quiesce();
        wr(8'd0, 32'h8000_0000);
        ticks(1);
        check("R7 irq raised", {31'd0, irq}, 32'd1);
        wr(8'd4, 32'hBFFF_FFFF);
        check("R7 write without bit 30 ignored", {31'd0, irq}, 32'd1);
        wr(8'd4, 32'h4000_0000);
        check("R7 cleared by bit 30", {31'd0, irq}, 32'd0);
        ticks(4);
        check("R4 one-shot no re-raise", {31'd0, irq}, 32'd0);

        // R8 expiry and clear in the same cycle
        quiesce();
        wr(8'd0, 32'hC000_0000);
        ticks(1);
        @(negedge clk);
        tick_1us = 1'b1; bus_wr = 1'b1; bus_addr = 8'd4; bus_wdata = 32'h4000_0000;
        @(negedge clk);
        tick_1us = 1'b0; bus_wr = 1'b0;
        check("R8 expiry beats clear", {31'd0, irq}, 32'd1);
        wr(8'd4, 32'h4000_0000);
        check("R8 later clear works", {31'd0, irq}, 32'd0);

        // R10 reset in the middle of operation
        wr(8'd0, 32'hC000_0000);
        ticks(1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R10 irq after reset", {31'd0, irq}, 32'd0);
        rd(8'd0, d); check("R10 cmd after reset", d, 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule